// File: doc/BRIEF.md
# Move Elimination Arbiter

This block sits in a rename stage and decides, in the same cycle a request is presented, whether a register-to-register move or a two-register swap can be satisfied by remapping instead of execution. A request carries one or two destination writes and one or two source reads, each with the register number and the register file it belongs to. Each write also carries two flags: whether the destination's class permits elimination, and whether a write to a narrow register clears its wide parent. The block holds an alias table and a known-zero flag for every architectural register. It also holds one elimination counter per register file, covering the current rename group.

The register space is split into `NWIDE` wide registers (top index bit 0) and `NWIDE` narrow registers (top index bit 1). Narrow register `{1,i}` is the sub-register of wide register `{0,i}`. A granted elimination makes each destination an alias of its source, resolving an existing source alias by one level. It copies the source's zero flag to the destination and reports zero-write/zero-read marks. Ordinary (executed) writes enter through a separate port that clears aliases and sets zero flags. A lookup port reads out the table.

There is no back-pressure. A request is a single-cycle strobe (`req_valid`) and is answered combinationally on `elim_ok` in the same cycle. The block can take one request and one ordinary write in every cycle. Table and counter updates land on the next rising clock edge.

Top module: `move_elim_arbiter`

## Requirements
- R1: A request can be granted only if `req_nwr == req_nrd` and that count is 1 (move) or 2 (swap); otherwise `elim_ok` is 0 and no state changes.
- R2: In a swap, read 0 is paired with write 1 and read 1 with write 0; in a move, read 0 is paired with write 0. `elim_zero_wr[w]` reports the write side of each pair, and `elim_zero_rd[k]` reports the read side.
- R3: Each file has a counter of eliminated pairs in the current group; `group_start` zeroes it for the request in that same cycle. A request is rejected when the file's 3-bit limit in `cap_limit[f*3 +: 3]` is nonzero and counter plus request size exceeds it. A limit of 0 means no cap, and the counter saturates at 7.
- R4: The group file is `wr_file[0]`; every paired source file and destination file must equal it.
- R5: A pair fails if its destination's `wr_allow` is 0. It also fails if its destination is narrow and `wr_full` is 0 (a partial write); for wide destinations `wr_full` has no effect on acceptance.
- R6: When `zero_only[f]` is 1 for the group file, a pair qualifies only if its source register's zero flag is set at the start of the cycle.
- R7: All pairs are judged against the state at the start of the cycle; if any pair fails, nothing in the table or counters changes.
- R8: On grant, the effective destination is the wide parent when `wr_full` is 1, otherwise the register itself. It takes alias = the source's alias if the source is aliased, else the source. If the effective destination is wide, its narrow sub-register takes the same alias. In a swap, pair 1 is applied after pair 0.
- R9: On grant, each pair whose source zero flag is set raises both its zero marks. The source zero flag is copied to the effective destination and its sub-register.
- R10: An ordinary write (`norm_valid`) clears the alias of `norm_reg`, and of its sub-register if it is wide. It sets their zero flags to `norm_zero`.
- R11: After reset no register is aliased, no zero flag is set and all counters are zero.
- R12: When an ordinary write and a granted elimination touch the same register in one cycle, the elimination's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| group_start | input | 1 | First cycle of a rename group; zeroes the per-file counters |
| cap_limit | input | NFILE*CNT_W | Per-file elimination limit per group, 0 = uncapped |
| zero_only | input | NFILE | Per-file mode: eliminate only moves of known-zero values |
| req_valid | input | 1 | Elimination request strobe |
| req_nwr | input | 2 | Number of writes in the request |
| req_nrd | input | 2 | Number of reads in the request |
| wr_reg | input | 2*REG_W | Destination registers, write 0 in low bits |
| wr_file | input | 2*FILE_W | File of each destination |
| wr_allow | input | 2 | Destination class permits elimination |
| wr_full | input | 2 | Destination write clears its wide parent |
| rd_reg | input | 2*REG_W | Source registers, read 0 in low bits |
| rd_file | input | 2*FILE_W | File of each source |
| elim_ok | output | 1 | Request granted |
| elim_zero_wr | output | 2 | Write marked as zero write, per write index |
| elim_zero_rd | output | 2 | Read marked as zero read, per read index |
| norm_valid | input | 1 | Ordinary write strobe |
| norm_reg | input | REG_W | Register of the ordinary write |
| norm_zero | input | 1 | Ordinary write produces zero |
| look_reg | input | REG_W | Table lookup index |
| look_alias_valid | output | 1 | Looked-up register is aliased |
| look_alias | output | REG_W | Alias target of looked-up register |
| look_zero | output | 1 | Zero flag of looked-up register |

## Verification
The hardest state to reach is a swap in which one pair qualifies and the other does not, because the failing pair depends on stored state. In zero-only mode it turns on a source zero flag, and the alias it would record depends on prior aliases. Reaching it needs both sources carrying earlier aliases and mixed zero flags. The stimulus seeds zero flags with ordinary writes and runs an exhaustive sweep of single moves to build chains of aliases. It then drives a long biased random run of swaps with changing zero-only modes and limits, and it compares the whole table after every cycle to confirm that a rejected swap left every entry untouched.

// File: rtl/mea_pkg.sv
package mea_pkg;
  localparam int MEA_NWIDE = 4;
  localparam int MEA_NFILE = 2;
  localparam int MEA_CNT_W = 3;
  typedef logic [1:0] req_size_t;
endpackage

// File: rtl/mea_pair_check.sv
module mea_pair_check #(
  parameter int REG_W  = 3,
  parameter int FILE_W = 1
) (
  input  logic [FILE_W-1:0] grp_file,
  input  logic [FILE_W-1:0] src_file,
  input  logic [FILE_W-1:0] dst_file,
  input  logic [REG_W-1:0]  dst_reg,
  input  logic              dst_allow,
  input  logic              dst_full,
  input  logic              src_zero,
  input  logic              zero_only,
  output logic              pair_ok
);
  logic dst_narrow;
  logic same_file;
  assign dst_narrow = dst_reg[REG_W-1];
  assign same_file  = (src_file == grp_file) && (dst_file == grp_file);
  assign pair_ok    = same_file && dst_allow && !(dst_narrow && !dst_full)
                      && (!zero_only || src_zero);
endmodule

// File: rtl/mea_cap_gate.sv
module mea_cap_gate #(
  parameter int NFILE  = 2,
  parameter int FILE_W = 1,
  parameter int CNT_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   group_start,
  input  logic [NFILE*CNT_W-1:0] cap_limit,
  input  logic [FILE_W-1:0]      req_file,
  input  mea_pkg::req_size_t     req_size,
  input  logic                   commit,
  output logic                   cap_ok
);
  logic [CNT_W-1:0] base_a [NFILE];
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   want;

  for (genvar f = 0; f < NFILE; f++) begin : g_file
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;
    logic             hit;
    assign base_a[f] = group_start ? '0 : cnt_q;
    assign hit       = commit && (req_file == FILE_W'(f));
    assign sum       = {1'b0, base_a[f]} + (hit ? {{(CNT_W-1){1'b0}}, req_size} : '0);
    always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (sum[CNT_W]) cnt_q <= '1;
      else               cnt_q <= sum[CNT_W-1:0];
    end
  end

  assign lim    = cap_limit[req_file*CNT_W +: CNT_W];
  assign want   = {1'b0, base_a[req_file]} + {{(CNT_W-1){1'b0}}, req_size};
  assign cap_ok = (lim == '0) || (want <= {1'b0, lim});
endmodule

// File: rtl/mea_alias_table.sv
module mea_alias_table #(
  parameter int NREG  = 8,
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             norm_valid,
  input  logic [REG_W-1:0] norm_reg,
  input  logic             norm_zero,
  input  logic [1:0]       upd_en,
  input  logic [REG_W-1:0] upd_dst [2],
  input  logic [REG_W-1:0] upd_src [2],
  output logic [1:0]       src_zero,
  input  logic [REG_W-1:0] look_reg,
  output logic             look_valid,
  output logic [REG_W-1:0] look_id,
  output logic             look_zero
);
  logic [NREG-1:0]  av_q, av_d, z_q, z_d;
  logic [REG_W-1:0] id_q [NREG];
  logic [REG_W-1:0] id_d [NREG];
  logic [REG_W-1:0] res  [2];

  function automatic logic covers(input logic [REG_W-1:0] x, input int r);
    return (REG_W'(r) == x) ||
           (!x[REG_W-1] && (REG_W'(r) == {1'b1, x[REG_W-2:0]}));
  endfunction

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      res[k]      = av_q[upd_src[k]] ? id_q[upd_src[k]] : upd_src[k];
      src_zero[k] = z_q[upd_src[k]];
    end
  end

  always_comb begin
    av_d = av_q;
    z_d  = z_q;
    for (int r = 0; r < NREG; r++) begin
      id_d[r] = id_q[r];
      if (norm_valid && covers(norm_reg, r)) begin
        av_d[r] = 1'b0;
        z_d[r]  = norm_zero;
      end
      for (int k = 0; k < 2; k++) begin
        if (upd_en[k] && covers(upd_dst[k], r)) begin
          av_d[r] = 1'b1;
          id_d[r] = res[k];
          z_d[r]  = src_zero[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      av_q <= '0;
      z_q  <= '0;
      for (int r = 0; r < NREG; r++) id_q[r] <= '0;
    end else begin
      av_q <= av_d;
      z_q  <= z_d;
      for (int r = 0; r < NREG; r++) id_q[r] <= id_d[r];
    end
  end

  assign look_valid = av_q[look_reg];
  assign look_id    = id_q[look_reg];
  assign look_zero  = z_q[look_reg];
endmodule

// File: rtl/move_elim_arbiter.sv
module move_elim_arbiter #(
  parameter int NWIDE = mea_pkg::MEA_NWIDE,
  parameter int NFILE = mea_pkg::MEA_NFILE,
  parameter int CNT_W = mea_pkg::MEA_CNT_W,
  localparam int REG_W  = $clog2(NWIDE) + 1,
  localparam int NREG   = 2 * NWIDE,
  localparam int FILE_W = (NFILE > 1) ? $clog2(NFILE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   group_start,
  input  logic [NFILE*CNT_W-1:0] cap_limit,
  input  logic [NFILE-1:0]       zero_only,
  input  logic                   req_valid,
  input  logic [1:0]             req_nwr,
  input  logic [1:0]             req_nrd,
  input  logic [2*REG_W-1:0]     wr_reg,
  input  logic [2*FILE_W-1:0]    wr_file,
  input  logic [1:0]             wr_allow,
  input  logic [1:0]             wr_full,
  input  logic [2*REG_W-1:0]     rd_reg,
  input  logic [2*FILE_W-1:0]    rd_file,
  output logic                   elim_ok,
  output logic [1:0]             elim_zero_wr,
  output logic [1:0]             elim_zero_rd,
  input  logic                   norm_valid,
  input  logic [REG_W-1:0]       norm_reg,
  input  logic                   norm_zero,
  input  logic [REG_W-1:0]       look_reg,
  output logic                   look_alias_valid,
  output logic [REG_W-1:0]       look_alias,
  output logic                   look_zero
);
  logic              is_swap, shape_ok, cap_ok;
  logic [FILE_W-1:0] grp_file;
  logic [1:0]        pair_ok, need, upd_en, src_zero, zr;
  logic [REG_W-1:0]  eff_dst [2];
  logic [REG_W-1:0]  src_reg [2];

  assign is_swap  = (req_nwr == 2'd2);
  assign shape_ok = (req_nwr == req_nrd) && ((req_nwr == 2'd1) || is_swap);
  assign grp_file = wr_file[FILE_W-1:0];
  assign need     = {is_swap, 1'b1};

  for (genvar k = 0; k < 2; k++) begin : g_pair
    localparam int WX = 1 - k;
    logic             wsel;
    logic [REG_W-1:0] d_reg;
    assign wsel       = is_swap ? WX[0] : 1'b0;
    assign d_reg      = wr_reg[wsel*REG_W +: REG_W];
    assign src_reg[k] = rd_reg[k*REG_W +: REG_W];
    assign eff_dst[k] = wr_full[wsel] ? {1'b0, d_reg[REG_W-2:0]} : d_reg;

    mea_pair_check #(.REG_W(REG_W), .FILE_W(FILE_W)) u_chk (
      .grp_file (grp_file),
      .src_file (rd_file[k*FILE_W +: FILE_W]),
      .dst_file (wr_file[wsel*FILE_W +: FILE_W]),
      .dst_reg  (d_reg),
      .dst_allow(wr_allow[wsel]),
      .dst_full (wr_full[wsel]),
      .src_zero (src_zero[k]),
      .zero_only(zero_only[grp_file]),
      .pair_ok  (pair_ok[k])
    );
  end

  assign elim_ok = req_valid && shape_ok && cap_ok && (&(pair_ok | ~need));
  assign upd_en  = elim_ok ? need : 2'b00;
  assign zr      = upd_en & src_zero;
  assign elim_zero_rd = zr;
  assign elim_zero_wr = is_swap ? {zr[0], zr[1]} : {1'b0, zr[0]};

  mea_cap_gate #(.NFILE(NFILE), .FILE_W(FILE_W), .CNT_W(CNT_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .group_start(group_start),
    .cap_limit  (cap_limit),
    .req_file   (grp_file),
    .req_size   (req_nwr),
    .commit     (elim_ok),
    .cap_ok     (cap_ok)
  );

  mea_alias_table #(.NREG(NREG), .REG_W(REG_W)) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .norm_valid(norm_valid),
    .norm_reg  (norm_reg),
    .norm_zero (norm_zero),
    .upd_en    (upd_en),
    .upd_dst   (eff_dst),
    .upd_src   (src_reg),
    .src_zero  (src_zero),
    .look_reg  (look_reg),
    .look_valid(look_alias_valid),
    .look_id   (look_alias),
    .look_zero (look_zero)
  );
endmodule

// File: rtl/mea_checker.sv
module mea_checker #(
  parameter int REG_W  = 3,
  parameter int FILE_W = 1,
  parameter int NFILE  = 2,
  parameter int CNT_W  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   group_start,
  input logic [NFILE*CNT_W-1:0] cap_limit,
  input logic                   req_valid,
  input logic [1:0]             req_nwr,
  input logic [1:0]             req_nrd,
  input logic [2*FILE_W-1:0]    wr_file,
  input logic [1:0]             wr_allow,
  input logic [2*FILE_W-1:0]    rd_file,
  input logic                   elim_ok,
  input logic [1:0]             elim_zero_wr,
  input logic [1:0]             elim_zero_rd,
  input logic                   norm_valid,
  input logic [REG_W-1:0]       norm_reg,
  input logic                   norm_zero,
  input logic [REG_W-1:0]       look_reg,
  input logic                   look_alias_valid,
  input logic                   look_zero
);
  logic [FILE_W-1:0] gf;
  logic [CNT_W-1:0]  lim;
  assign gf  = wr_file[FILE_W-1:0];
  assign lim = cap_limit[gf*CNT_W +: CNT_W];

  // R1
  shape_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elim_ok |-> (req_nwr == req_nrd) && (req_nwr == 2'd1 || req_nwr == 2'd2));
  // R4
  same_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elim_ok |-> (rd_file[FILE_W-1:0] == gf) &&
                (req_nwr != 2'd2 || (wr_file[2*FILE_W-1:FILE_W] == gf &&
                                     rd_file[2*FILE_W-1:FILE_W] == gf)));
  // R5
  class_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elim_ok |-> wr_allow[0] && (req_nwr != 2'd2 || wr_allow[1]));
  // R3
  group_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elim_ok && group_start && lim != '0) |-> ({1'b0, req_nwr} <= {1'b0, lim}));
  // R9
  zero_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elim_zero_wr != 2'b00 || elim_zero_rd != 2'b00) |->
      elim_ok && ($countones(elim_zero_wr) == $countones(elim_zero_rd)));
  // R7
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !elim_ok);
  // R10
  norm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(norm_valid && !elim_ok) && look_reg == $past(norm_reg)) |->
      (!look_alias_valid && look_zero == $past(norm_zero)));
endmodule

bind move_elim_arbiter mea_checker #(
  .REG_W(REG_W), .FILE_W(FILE_W), .NFILE(NFILE), .CNT_W(CNT_W)
) u_mea_chk (
  .clk(clk), .rst_n(rst_n), .group_start(group_start), .cap_limit(cap_limit),
  .req_valid(req_valid), .req_nwr(req_nwr), .req_nrd(req_nrd),
  .wr_file(wr_file), .wr_allow(wr_allow), .rd_file(rd_file),
  .elim_ok(elim_ok), .elim_zero_wr(elim_zero_wr), .elim_zero_rd(elim_zero_rd),
  .norm_valid(norm_valid), .norm_reg(norm_reg), .norm_zero(norm_zero),
  .look_reg(look_reg), .look_alias_valid(look_alias_valid), .look_zero(look_zero)
);

// File: tb/move_elim_arbiter_bench.sv
`timescale 1ns/1ps
module move_elim_arbiter_bench;
  localparam int NR = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       group_start, req_valid, norm_valid, norm_zero;
  logic [5:0] cap_limit;
  logic [1:0] zero_only, req_nwr, req_nrd, wr_allow, wr_full, wr_file, rd_file;
  logic [2:0] b_wr [2];
  logic [2:0] b_rd [2];
  logic [5:0] wr_reg, rd_reg;
  logic [2:0] norm_reg, look_reg, look_alias;
  logic       elim_ok, look_alias_valid, look_zero;
  logic [1:0] elim_zero_wr, elim_zero_rd;
  assign wr_reg = {b_wr[1], b_wr[0]};
  assign rd_reg = {b_rd[1], b_rd[0]};

  move_elim_arbiter u_move_elim_arbiter (
    .clk(clk), .rst_n(rst_n), .group_start(group_start), .cap_limit(cap_limit),
    .zero_only(zero_only), .req_valid(req_valid), .req_nwr(req_nwr), .req_nrd(req_nrd),
    .wr_reg(wr_reg), .wr_file(wr_file), .wr_allow(wr_allow), .wr_full(wr_full),
    .rd_reg(rd_reg), .rd_file(rd_file), .elim_ok(elim_ok), .elim_zero_wr(elim_zero_wr),
    .elim_zero_rd(elim_zero_rd), .norm_valid(norm_valid), .norm_reg(norm_reg),
    .norm_zero(norm_zero), .look_reg(look_reg), .look_alias_valid(look_alias_valid),
    .look_alias(look_alias), .look_zero(look_zero));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_av [NR];
  int m_id [NR];
  int m_z  [NR];
  int m_cnt [2];
  bit e_ok, last_rej;
  logic [1:0] e_zw, e_zr;
  string e_tag;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit cov(int x, int r);
    return (r == x) || (x < 4 && r == x + 4);
  endfunction

  task automatic predict();
    int n, f, used, lim;
    bit pair_fail, cap_fail, file_fail, cls_fail, zo_fail;
    n = req_nwr; f = wr_file[0];
    e_zw = 2'b00; e_zr = 2'b00;
    pair_fail = 0; file_fail = 0; cls_fail = 0; zo_fail = 0;
    used = group_start ? 0 : m_cnt[f];
    lim  = (cap_limit >> (3*f)) & 7;
    cap_fail = (lim != 0) && (used + n > lim);
    for (int k = 0; k < 2; k++) begin
      int w;
      if (k < n) begin
        w = (n == 2) ? 1 - k : 0;
        if (rd_file[k] != f || wr_file[w] != f) file_fail = 1;
        else if (!wr_allow[w] || (b_wr[w] >= 4 && !wr_full[w])) cls_fail = 1;
        else if (zero_only[f] && !m_z[b_rd[k]]) zo_fail = 1;
      end
    end
    pair_fail = file_fail | cls_fail | zo_fail;
    if (!(req_nwr == req_nrd && (n == 1 || n == 2))) begin e_ok = 0; e_tag = "R1"; end
    else if (cap_fail)  begin e_ok = 0; e_tag = "R3"; end
    else if (file_fail) begin e_ok = 0; e_tag = "R4"; end
    else if (cls_fail)  begin e_ok = 0; e_tag = "R5"; end
    else if (zo_fail)   begin e_ok = 0; e_tag = "R6"; end
    else begin e_ok = 1; e_tag = (n == 2) ? "R2" : "R8"; end
    if (!req_valid) begin e_ok = 0; e_tag = "R7"; end
    if (e_ok) for (int k = 0; k < n; k++) begin
      int w;
      w = (n == 2) ? 1 - k : 0;
      e_zr[k] = m_z[b_rd[k]][0];
      e_zw[w] = m_z[b_rd[k]][0];
    end
  endtask

  task automatic update();
    int o_av [NR]; int o_id [NR]; int o_z [NR];
    int n, f;
    n = req_nwr; f = wr_file[0];
    o_av = m_av; o_id = m_id; o_z = m_z;
    for (int r = 0; r < NR; r++)
      if (norm_valid && cov(norm_reg, r)) begin m_av[r] = 0; m_z[r] = norm_zero; end
    if (e_ok) for (int k = 0; k < n; k++) begin
      int w, eff, s;
      w = (n == 2) ? 1 - k : 0;
      eff = wr_full[w] ? (b_wr[w] & 3) : b_wr[w];
      s = b_rd[k];
      for (int r = 0; r < NR; r++) if (cov(eff, r)) begin
        m_av[r] = 1; m_id[r] = o_av[s] ? o_id[s] : s; m_z[r] = o_z[s];
      end
    end
    for (int g = 0; g < 2; g++) begin
      int c;
      c = group_start ? 0 : m_cnt[g];
      if (e_ok && g == f) c += n;
      m_cnt[g] = (c > 7) ? 7 : c;
    end
    last_rej = req_valid && !e_ok;
  endtask

  task automatic table_chk(input string tag);
    for (int r = 0; r < NR; r++) begin
      look_reg = 3'(r);
      #1;
      chk(look_alias_valid, m_av[r], tag);
      if (m_av[r] != 0) chk(look_alias, m_id[r], tag);
      chk(look_zero, m_z[r], "R9 R10");
    end
  endtask

  task automatic step();
    predict();
    #5;
    chk(elim_ok, e_ok, e_tag);
    chk(elim_zero_wr, e_zw, "R9 R2");
    chk(elim_zero_rd, e_zr, "R9");
    @(posedge clk);
    update();
    #1;
    table_chk(last_rej ? "R7" : "R8");
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 0; norm_valid = 0; group_start = 1; req_nwr = 0; req_nrd = 0;
    wr_file = 0; rd_file = 0; wr_allow = 0; wr_full = 0; cap_limit = 0; zero_only = 0;
    b_wr[0] = 0; b_wr[1] = 0; b_rd[0] = 0; b_rd[1] = 0; norm_reg = 0; norm_zero = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(); look_reg = 0;
    for (int r = 0; r < NR; r++) begin m_av[r] = 0; m_id[r] = 0; m_z[r] = 0; end
    m_cnt[0] = 0; m_cnt[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5 chk(elim_ok, 0, "R11");
    table_chk("R11");
    @(negedge clk);

    // R10: seed zero flags with ordinary writes
    for (int i = 0; i < 40; i++) begin
      idle(); norm_valid = 1; norm_reg = 3'($urandom_range(7, 0)); norm_zero = 1'($urandom);
      step();
    end

    // R5 R6 R8 R9: exhaustive single moves
    for (int zo = 0; zo < 2; zo++)
      for (int s = 0; s < NR; s++)
        for (int d = 0; d < NR; d++)
          for (int af = 0; af < 4; af++) begin
            idle();
            zero_only = zo[0] ? 2'b11 : 2'b00;
            req_valid = 1; req_nwr = 1; req_nrd = 1;
            b_rd[0] = 3'(s); b_wr[0] = 3'(d); wr_allow = {1'b0, af[0]}; wr_full = {1'b0, af[1]};
            norm_valid = 1'($urandom); norm_reg = 3'($urandom_range(7, 0)); norm_zero = 1'($urandom);
            step();
          end

    // R12: elimination beats ordinary write on the same register
    idle(); req_valid = 1; req_nwr = 1; req_nrd = 1; b_rd[0] = 5; b_wr[0] = 2;
    wr_allow = 2'b01; norm_valid = 1; norm_reg = 2;
    step();
    look_reg = 2; #1 chk(look_alias_valid, 1, "R12");
    @(negedge clk);

    // R1 R2 R3 R4 R6 R7: biased random moves and swaps
    for (int i = 0; i < 4000; i++) begin
      int sz;
      idle();
      if (i % 50 == 0) begin
        cap_limit = 6'($urandom_range(63, 0)) & 6'b011011;
        zero_only = 2'($urandom);
      end
      sz = $urandom_range(2, 1);
      if ($urandom_range(9, 0) < 8) begin req_nwr = 2'(sz); req_nrd = 2'(sz); end
      else begin req_nwr = 2'($urandom); req_nrd = 2'($urandom); end
      req_valid = ($urandom_range(9, 0) != 0);
      group_start = ($urandom_range(9, 0) < 3);
      wr_file[0] = 1'($urandom);
      wr_file[1] = ($urandom_range(9, 0) < 9) ? wr_file[0] : ~wr_file[0];
      for (int k = 0; k < 2; k++) begin
        rd_file[k] = ($urandom_range(9, 0) < 9) ? wr_file[0] : ~wr_file[0];
        wr_allow[k] = ($urandom_range(9, 0) < 9);
        wr_full[k] = 1'($urandom);
        b_wr[k] = 3'($urandom_range(7, 0));
        b_rd[k] = 3'($urandom_range(7, 0));
      end
      norm_valid = 1'($urandom); norm_reg = 3'($urandom_range(7, 0)); norm_zero = 1'($urandom);
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule